// File: doc/BRIEF.md
# Interrupt Vector Dispatch Register

This block sits between a set of level-sensitive device interrupt lines and a processor core. It accepts two kinds of sources: a bus of direct vector lines, one per vector number, and a small group of legacy numbered lines. The legacy lines are routed to vector numbers through a sparse table that is fixed at build time. Every source line is compared with its level from the previous cycle, which gives a rise and a fall for each line.

The block holds only one vector at a time. When a line rises and the block is idle, it records the vector number in the first of three 64-bit data words and becomes busy. While busy, it requests a vector interrupt from the processor and presents the vector interrupt type code. A device acknowledges the interrupt by lowering its line. A fall on any line releases the block, and it can then capture the next rise. A rise that arrives while the block is busy is lost.

Top module: `ivd_dispatch`

## Requirements
- R1: The legacy lines route to fixed vector numbers: line 1 to 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A.
- R2: A legacy line with no route (any line other than 1, 4, 6, 7 and 12) has no effect on busy, the request or the data words.
- R3: When a line rises and the block is idle, the block becomes busy in the cycle after the sampling clock edge. At the same time, word 0 becomes the value 0x1F placed at bits 10..6, OR'ed with the vector number in bits 5..0, and words 1 and 2 become zero.
- R4: While busy, the request output is high and the type output carries 0x060. While idle, both outputs are zero.
- R5: A rise that arrives while busy is dropped. Busy stays set and the data words keep their values.
- R6: A fall on any line while busy clears busy and withdraws the request after the next clock edge. The data words keep their last values.
- R7: When several lines rise in the same cycle and the block is idle, the lowest vector number is captured.
- R8: During and after reset, busy and the request are clear and all three data words are zero.
- R9: Only a low-to-high transition causes a capture. A line that stays high does not cause a capture on later cycles.
- R10: When a fall and a rise arrive in the same cycle while busy, the fall releases the block and the rise is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_irq_i | input | 16 | Legacy numbered interrupt levels |
| vec_line_i | input | 64 | Direct interrupt levels, one per vector number |
| busy_o | output | 1 | A vector is held |
| req_o | output | 1 | Vector interrupt request to the processor |
| kind_o | output | 9 | Interrupt type code, 0x060 while busy |
| word0_o | output | 64 | Data word 0: tag and vector number |
| word1_o | output | 64 | Data word 1, cleared on capture |
| word2_o | output | 64 | Data word 2, cleared on capture |

## Verification
The bench builds the block with its default parameters: 16 legacy lines, 64 vector lines, the routing table enabled, a 5-bit tag of 0x1F at shift 6, and type code 0x060. These defaults make every routed legacy line reachable, along with both ends of the vector range (0 and 63). A behavioural model compares all outputs on every clock. Directed sequences cover rises while busy, a fall and a rise in the same cycle, lines held high after release, and several lines rising together.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

   // Returns the vector number a legacy line is routed to, or -1 when the line has no route.
   function automatic int legacy_route(input int line);
      case (line)
         1:       return 'h29;
         4:       return 'h2B;
         6:       return 'h27;
         7:       return 'h22;
         12:      return 'h2A;
         default: return -1;
      endcase
   endfunction

   // Largest vector number used by the routing table.
   localparam int ROUTE_MAX_VEC = 'h2B;

   typedef enum logic [0:0] {
      HOLD_IDLE = 1'b0,
      HOLD_BUSY = 1'b1
   } hold_e;

endpackage

// File: rtl/ivd_legacy_map.sv
module ivd_legacy_map #(
   parameter int NUM_LEGACY = 16,
   parameter int NUM_VEC    = 64,
   parameter bit USE_MAP    = 1'b1
) (
   input  logic [NUM_LEGACY-1:0] legacy_i,
   output logic [NUM_VEC-1:0]    routed_o
);
   import ivd_pkg::*;

   // Builds the mask of legacy lines that drive a given vector.
   function automatic logic [NUM_LEGACY-1:0] src_mask(input int v);
      logic [NUM_LEGACY-1:0] m;
      m = '0;
      for (int l = 0; l < NUM_LEGACY; l++) begin
         if (legacy_route(l) == v) m[l] = 1'b1;
      end
      return m;
   endfunction

   generate
      if (USE_MAP) begin : g_map
         if (NUM_VEC <= ROUTE_MAX_VEC) begin : g_chk
            $error("ivd_legacy_map: NUM_VEC too small for routing table");
         end
         for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
            localparam logic [NUM_LEGACY-1:0] MASK = src_mask(v);
            assign routed_o[v] = |(legacy_i & MASK);
         end
      end else begin : g_nomap
         logic unused_legacy;
         assign unused_legacy = ^legacy_i;
         assign routed_o = '0;
      end
   endgenerate

endmodule

// File: rtl/ivd_edge_detect.sv
module ivd_edge_detect #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;

   // R9: a line that rose cannot rise again in the very next cycle
   a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/ivd_prio_pick.sv
module ivd_prio_pick #(
   parameter int W     = 64,
   parameter int IDX_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

   // R7: the chosen index is set and no lower index is set
   a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (req_i[idx_o] && ((req_i & ((W'(1) << idx_o) - W'(1))) == '0)));

endmodule

// File: rtl/ivd_capture.sv
module ivd_capture #(
   parameter int          WORD_W    = 64,
   parameter int          VEC_W     = 6,
   parameter int          TAG_W     = 5,
   parameter int          TAG_SHIFT = 6,
   parameter logic [TAG_W-1:0] TAG_VALUE = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pick_valid_i,
   input  logic [VEC_W-1:0]  pick_idx_i,
   input  logic              any_fall_i,
   output logic              busy_o,
   output logic [WORD_W-1:0] word0_o,
   output logic [WORD_W-1:0] word1_o,
   output logic [WORD_W-1:0] word2_o
);
   import ivd_pkg::*;

   localparam logic [WORD_W-1:0] TAG_FIELD = WORD_W'(TAG_VALUE) << TAG_SHIFT;

   hold_e             state_q;
   logic [WORD_W-1:0] w0_q, w1_q, w2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= HOLD_IDLE;
         w0_q    <= '0;
         w1_q    <= '0;
         w2_q    <= '0;
      end else begin
         case (state_q)
            HOLD_BUSY: begin
               if (any_fall_i) state_q <= HOLD_IDLE;
            end
            default: begin
               if (pick_valid_i) begin
                  state_q <= HOLD_BUSY;
                  w0_q    <= TAG_FIELD | WORD_W'(pick_idx_i);
                  w1_q    <= '0;
                  w2_q    <= '0;
               end
            end
         endcase
      end
   end

   assign busy_o  = (state_q == HOLD_BUSY);
   assign word0_o = w0_q;
   assign word1_o = w1_q;
   assign word2_o = w2_q;

   // R3: a pick while idle produces busy and the tagged vector number
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && pick_valid_i) |=>
         (busy_o && word0_o == (TAG_FIELD | WORD_W'($past(pick_idx_i))) && word1_o == '0 && word2_o == '0));

   // R5: with no fall, a held vector and its data stay put
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !any_fall_i) |=> (busy_o && $stable(word0_o) && $stable(word1_o) && $stable(word2_o)));

   // R6 / R10: a fall while busy releases the block and keeps data
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && any_fall_i) |=> (!busy_o && $stable(word0_o)));

endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch #(
   parameter int               NUM_LEGACY     = 16,
   parameter int               NUM_VEC        = 64,
   parameter int               WORD_W         = 64,
   parameter int               TAG_W          = 5,
   parameter int               TAG_SHIFT      = 6,
   parameter logic [TAG_W-1:0] TAG_VALUE      = 5'h1F,
   parameter int               KIND_W         = 9,
   parameter logic [KIND_W-1:0] VEC_KIND      = 9'h060,
   parameter bit               USE_LEGACY_MAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEGACY-1:0] legacy_irq_i,
   input  logic [NUM_VEC-1:0]    vec_line_i,
   output logic                  busy_o,
   output logic                  req_o,
   output logic [KIND_W-1:0]     kind_o,
   output logic [WORD_W-1:0]     word0_o,
   output logic [WORD_W-1:0]     word1_o,
   output logic [WORD_W-1:0]     word2_o
);
   localparam int VEC_W = $clog2(NUM_VEC);

   if (TAG_SHIFT < VEC_W) begin : g_chk_shift
      $error("ivd_dispatch: tag field overlaps the vector number");
   end
   if (TAG_SHIFT + TAG_W > WORD_W) begin : g_chk_word
      $error("ivd_dispatch: tag field does not fit the data word");
   end

   logic [NUM_VEC-1:0] routed, lvl, rise, fall;
   logic               pick_valid;
   logic [VEC_W-1:0]   pick_idx;

   ivd_legacy_map #(
      .NUM_LEGACY (NUM_LEGACY),
      .NUM_VEC    (NUM_VEC),
      .USE_MAP    (USE_LEGACY_MAP)
   ) u_map (
      .legacy_i (legacy_irq_i),
      .routed_o (routed)
   );

   assign lvl = vec_line_i | routed;

   ivd_edge_detect #(.W(NUM_VEC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   ivd_prio_pick #(.W(NUM_VEC), .IDX_W(VEC_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (rise),
      .valid_o (pick_valid),
      .idx_o   (pick_idx)
   );

   ivd_capture #(
      .WORD_W    (WORD_W),
      .VEC_W     (VEC_W),
      .TAG_W     (TAG_W),
      .TAG_SHIFT (TAG_SHIFT),
      .TAG_VALUE (TAG_VALUE)
   ) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .pick_valid_i (pick_valid),
      .pick_idx_i   (pick_idx),
      .any_fall_i   (|fall),
      .busy_o       (busy_o),
      .word0_o      (word0_o),
      .word1_o      (word1_o),
      .word2_o      (word2_o)
   );

   assign req_o  = busy_o;
   assign kind_o = busy_o ? VEC_KIND : '0;

   // R4: a new request always follows a rising line picked while idle
   a_r4_req_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o) |-> $past(pick_valid));

   // R2: unrouted legacy lines cannot reach the vector levels
   a_r2_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_line_i == '0 && (legacy_irq_i & 16'h10D2) == '0) |-> (lvl == '0));

endmodule

// File: tb/sim_ivd_dispatch.sv
module sim_ivd_dispatch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] leg = '0;
   logic [63:0] vec = '0;
   logic        busy, req;
   logic [8:0]  kind;
   logic [63:0] w0, w1, w2;

   int checks = 0;
   int fails  = 0;

   // behavioural model state
   bit          m_busy = 1'b0;
   logic [63:0] m_d0 = '0, m_d1 = '0, m_d2 = '0;
   logic [63:0] m_prev = '0;

   always #5 clk = ~clk;

   ivd_dispatch u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .legacy_irq_i (leg),
      .vec_line_i   (vec),
      .busy_o       (busy),
      .req_o        (req),
      .kind_o       (kind),
      .word0_o      (w0),
      .word1_o      (w1),
      .word2_o      (w2)
   );

   function automatic int route(input int line);
      case (line)
         1: return 41;  4: return 43;  6: return 39;  7: return 34;  12: return 42;
         default: return -1;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic mdl_step();
      logic [63:0] lv;
      lv = vec;
      for (int l = 0; l < 16; l++) if (leg[l] && route(l) >= 0) lv[route(l)] = 1'b1;
      if (m_busy && ((m_prev & ~lv) != 0)) m_busy = 1'b0;
      else if (!m_busy) begin
         for (int i = 0; i < 64; i++) begin
            if (lv[i] && !m_prev[i]) begin
               m_busy = 1'b1;
               m_d0 = 64'h7C0 | 64'(i);
               m_d1 = '0;
               m_d2 = '0;
               break;
            end
         end
      end
      m_prev = lv;
   endtask

   task automatic cmp_all();
      chk(busy == m_busy, "R3 busy", 64'(busy), 64'(m_busy));
      chk(req == m_busy, "R4 req", 64'(req), 64'(m_busy));
      chk(kind == (m_busy ? 9'h060 : 9'h000), "R4 kind", 64'(kind), m_busy ? 64'h60 : 64'h0);
      chk(w0 == m_d0, "R3 word0", w0, m_d0);
      chk(w1 == m_d1 && w2 == m_d2, "R3 words1-2", w1 | w2, 64'h0);
   endtask

   task automatic cyc(input logic [15:0] l, input logic [63:0] v);
      leg = l;
      vec = v;
      @(posedge clk);
      mdl_step();
      #2;
      cmp_all();
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(!busy && !req && w0 == 0 && w1 == 0 && w2 == 0, "R8 reset", w0, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 keyboard route
      cyc(16'h0002, '0);
      chk(w0 == 64'h7E9 && busy, "R1 line1", w0, 64'h7E9);
      // R5 rise while busy dropped
      cyc(16'h0012, '0);
      chk(w0 == 64'h7E9 && busy, "R5 dropped", w0, 64'h7E9);
      // R6 fall of any line releases
      cyc(16'h0002, '0);
      chk(!busy && !req && w0 == 64'h7E9, "R6 release", 64'(busy), 64'h0);
      cyc(16'h0000, '0);
      // R2 unrouted legacy lines
      cyc(16'hEF2D, '0);
      chk(!busy && w0 == 64'h7E9, "R2 unrouted", 64'(busy), 64'h0);
      cyc(16'h0000, '0);
      chk(!busy, "R2 unrouted fall", 64'(busy), 64'h0);

      // R1 remaining routes
      cyc(16'h0010, '0);
      chk(w0 == 64'h7EB, "R1 line4", w0, 64'h7EB);
      cyc(16'h0000, '0);
      cyc(16'h0040, '0);
      chk(w0 == 64'h7E7, "R1 line6", w0, 64'h7E7);
      cyc(16'h0000, '0);
      cyc(16'h0080, '0);
      chk(w0 == 64'h7E2, "R1 line7", w0, 64'h7E2);
      cyc(16'h0000, '0);
      cyc(16'h1000, '0);
      chk(w0 == 64'h7EA, "R1 line12", w0, 64'h7EA);
      cyc(16'h0000, '0);

      // R7 lowest of several
      cyc(16'h1000, (64'h1 << 40) | (64'h1 << 9));
      chk(w0 == 64'h7C9, "R7 lowest", w0, 64'h7C9);
      cyc(16'h0000, '0);

      // R3 range ends
      cyc(16'h0000, 64'h1 << 63);
      chk(w0 == 64'h7FF && kind == 9'h060, "R3 vec63", w0, 64'h7FF);
      cyc(16'h0000, '0);
      cyc(16'h0000, 64'h1);
      chk(w0 == 64'h7C0, "R3 vec0", w0, 64'h7C0);
      cyc(16'h0000, '0);
      chk(!req && kind == 0, "R4 idle", 64'(kind), 64'h0);

      // R9 held line does not recapture
      cyc(16'h0000, 64'h60);
      chk(w0 == 64'h7C5, "R9 capture5", w0, 64'h7C5);
      cyc(16'h0000, 64'h20);
      cyc(16'h0000, 64'h20);
      chk(!busy, "R9 held", 64'(busy), 64'h0);
      cyc(16'h0000, '0);

      // R10 fall and rise together while busy
      cyc(16'h0000, 64'h4);
      chk(w0 == 64'h7C2, "R10 setup", w0, 64'h7C2);
      cyc(16'h0000, 64'h8);
      chk(!busy && w0 == 64'h7C2, "R10 release", 64'(busy), 64'h0);
      cyc(16'h0000, 64'h8);
      chk(!busy, "R10 dropped", 64'(busy), 64'h0);
      cyc(16'h0000, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule